// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Generator

This block turns one signed angle into its cosine and sine using the CORDIC rotation method, one micro-rotation per clock. The angle is a Q0.15 fraction of a full turn, so the representable range of -1.0 to just under +1.0 spans -360° to +360°. A quadrant folding stage first maps any such angle into the -90° to +90° band where the iterations converge. It records whether the final pair must be negated. The X register starts at the reciprocal CORDIC gain, so no multiply is needed at the end.

The input side is a valid/ready handshake. `start` acts as the valid and `ready` as the ready. An angle is taken on a rising edge where both are high. While a calculation runs, `ready` is low and any `start` is ignored; the caller must hold its request until `ready` returns. The output side has no back-pressure. `done` rises when the pair is valid and stays high, with both outputs frozen, until the next accepted start or a reset. An asynchronous active-high reset returns the block to idle at once, and callers may pulse it before each new angle.

Top module: `cordic_sincos`

## Requirements
- R1: While and after reset with no start, `ready`=1, `done`=0, `cos_out`=0 and `sin_out`=0; asserting `rst` takes effect without waiting for a clock edge.
- R2: An angle is accepted on a rising edge where `start` and `ready` are both 1. On the next edge `ready` and `done` read 0, and `done` rises on the 14th rising edge after the accepting edge, together with `ready`.
- R3: A `start` seen while `ready`=0 is ignored: the running result, its angle and its timing are unchanged.
- R4: `angle` is signed Q0.15 where value/32768 is the fraction of a full turn (8192 = 90°, 16384 = 180°, -32768 = -360°). `cos_out` and `sin_out` are signed Q0.15 and lie within 8 LSB of 32768·cos and 32768·sin of that angle.
- R5: While `done`=1 and no start is accepted, `done` stays 1 and both outputs hold their values.
- R6: Outputs saturate to the range -32768..32767 instead of wrapping; at 0° `cos_out` is positive and at least 32759.
- R7: Angles that differ by exactly one full turn give bit-identical outputs (for example 90° and -270°, 0° and -360°), and the folded angle fed to the iterations never exceeds a quarter turn in magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| start | input | 1 | Request valid: accept `angle` when `ready` is high |
| angle | input | 16 | Signed Q0.15 angle as a fraction of a turn |
| ready | output | 1 | Block can accept a new angle |
| done | output | 1 | Result valid; held until next accepted start or reset |
| cos_out | output | 16 | Cosine, signed Q0.15 |
| sin_out | output | 16 | Sine, signed Q0.15 |

## Verification
On every cycle the assertions watch the handshake and hold rules: an acceptance drops `ready` and `done`, `done` appears only after the final iteration count, a request during a run merely advances the count, a held result stays frozen, and the folded angle stays within a quarter turn. Numerical accuracy against true sine and cosine can only be shown by the bench. It drives the cardinal angles, full-turn aliases, a pseudo-random sweep, a request injected mid-run and a reset mid-run, and it compares `ready` and `done` against its own cycle model on every clock.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // arctangent table is written with 23 fractional bits of a full turn
  localparam int TABLE_FRAC = 23;

  // reciprocal of the CORDIC gain, unsigned Q0.31
  localparam logic [31:0] INV_GAIN_Q31 = 32'd1304065748;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} cordic_state_e;

  // atan(2^-i) expressed as a fraction of a turn, scaled to 'frac' bits
  function automatic logic [31:0] atan_turns(input int unsigned i, input int frac);
    logic [31:0] b;
    case (i)
      0:  b = 32'd1048576;
      1:  b = 32'd619011;
      2:  b = 32'd327068;
      3:  b = 32'd166025;
      4:  b = 32'd83335;
      5:  b = 32'd41708;
      6:  b = 32'd20859;
      7:  b = 32'd10430;
      8:  b = 32'd5215;
      9:  b = 32'd2608;
      10: b = 32'd1304;
      11: b = 32'd652;
      12: b = 32'd326;
      13: b = 32'd163;
      default: b = 32'd1335089 >> i;
    endcase
    if (frac >= TABLE_FRAC) atan_turns = b << (frac - TABLE_FRAC);
    else                    atan_turns = b >> (TABLE_FRAC - frac);
  endfunction

endpackage

// File: rtl/cordic_fold.sv
module cordic_fold #(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0]        angle,
  output logic signed [IN_W-1:0] folded,
  output logic                   negate
);
  localparam logic signed [IN_W-1:0] QTR  = {3'b001, {(IN_W-3){1'b0}}};
  localparam logic signed [IN_W-1:0] HALF = {2'b01, {(IN_W-2){1'b0}}};

  logic signed [IN_W-1:0] wrapped;

  // drop whole turns: keep the angle inside -180..+180 degrees
  assign wrapped = {angle[IN_W-2], angle[IN_W-2:0]};

  always_comb begin
    folded = wrapped;
    negate = 1'b0;
    if (wrapped > QTR) begin
      folded = wrapped - HALF;
      negate = 1'b1;
    end else if (wrapped < -QTR) begin
      folded = wrapped + HALF;
      negate = 1'b1;
    end
  end
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
  import cordic_pkg::*;
#(
  parameter int XW = 21,
  parameter int ZW = 24,
  parameter int IW = 4
) (
  input  logic signed [XW-1:0] x_in,
  input  logic signed [XW-1:0] y_in,
  input  logic signed [ZW-1:0] z_in,
  input  logic [IW-1:0]        idx,
  output logic signed [XW-1:0] x_out,
  output logic signed [XW-1:0] y_out,
  output logic signed [ZW-1:0] z_out
);
  logic signed [XW-1:0] x_sh, y_sh;
  logic signed [ZW-1:0] step;
  logic [31:0]          step_full;

  assign step_full = atan_turns(int'(idx), ZW - 1);
  assign step      = step_full[ZW-1:0];
  assign x_sh      = x_in >>> idx;
  assign y_sh      = y_in >>> idx;

  always_comb begin
    if (z_in[ZW-1]) begin
      x_out = x_in + y_sh;
      y_out = y_in - x_sh;
      z_out = z_in + step;
    end else begin
      x_out = x_in - y_sh;
      y_out = y_in + x_sh;
      z_out = z_in - step;
    end
  end
endmodule

// File: rtl/cordic_out.sv
module cordic_out #(
  parameter int XW    = 21,
  parameter int GUARD = 4,
  parameter int OUT_W = 16
) (
  input  logic signed [XW-1:0]    val,
  input  logic                    negate,
  output logic signed [OUT_W-1:0] res
);
  localparam logic signed [XW:0]   HALF_LSB = (XW+1)'(1 << (GUARD - 1));
  localparam logic signed [XW+1:0] MAXV = (XW+2)'(2**(OUT_W-1) - 1);
  localparam logic signed [XW+1:0] MINV = -(XW+2)'(2**(OUT_W-1));

  logic signed [XW:0]   rounded, scaled;
  logic signed [XW+1:0] signed_v;

  assign rounded  = {val[XW-1], val} + HALF_LSB;
  assign scaled   = rounded >>> GUARD;
  assign signed_v = negate ? -{scaled[XW], scaled} : {scaled[XW], scaled};

  always_comb begin
    if (signed_v > MAXV)      res = MAXV[OUT_W-1:0];
    else if (signed_v < MINV) res = MINV[OUT_W-1:0];
    else                      res = signed_v[OUT_W-1:0];
  end
endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
  import cordic_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int ITER   = 14,
  parameter int GUARD  = 4,
  parameter int ZGUARD = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OUT_W-1:0] angle,
  output logic             ready,
  output logic             done,
  output logic [OUT_W-1:0] cos_out,
  output logic [OUT_W-1:0] sin_out
);
  localparam int XW = OUT_W + GUARD + 1;
  localparam int ZW = OUT_W + ZGUARD;
  localparam int IW = $clog2(ITER + 1);
  localparam logic [IW-1:0] LAST = IW'(ITER - 1);
  localparam logic signed [XW-1:0] INIT_X =
    XW'(INV_GAIN_Q31 >> (31 - (OUT_W - 1 + GUARD)));
  localparam logic signed [ZW-1:0] QTR_Z = {3'b001, {(ZW-3){1'b0}}};

  cordic_state_e        st;
  logic signed [XW-1:0] x_q, y_q, x_n, y_n;
  logic signed [ZW-1:0] z_q, z_n;
  logic [IW-1:0]        cnt;
  logic                 neg_q, neg_w, accept;
  logic signed [OUT_W-1:0] fold_w, cos_w, sin_w, cos_q, sin_q;

  assign ready   = (st != ST_RUN);
  assign done    = (st == ST_HOLD);
  assign accept  = start && ready;
  assign cos_out = cos_q;
  assign sin_out = sin_q;

  cordic_fold #(.IN_W(OUT_W)) u_fold (
    .angle(angle), .folded(fold_w), .negate(neg_w)
  );

  cordic_stage #(.XW(XW), .ZW(ZW), .IW(IW)) u_stage (
    .x_in(x_q), .y_in(y_q), .z_in(z_q), .idx(cnt),
    .x_out(x_n), .y_out(y_n), .z_out(z_n)
  );

  cordic_out #(.XW(XW), .GUARD(GUARD), .OUT_W(OUT_W)) u_cos (
    .val(x_n), .negate(neg_q), .res(cos_w)
  );

  cordic_out #(.XW(XW), .GUARD(GUARD), .OUT_W(OUT_W)) u_sin (
    .val(y_n), .negate(neg_q), .res(sin_w)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st    <= ST_IDLE;
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      cnt   <= '0;
      neg_q <= 1'b0;
      cos_q <= '0;
      sin_q <= '0;
    end else if (accept) begin
      st    <= ST_RUN;
      x_q   <= INIT_X;
      y_q   <= '0;
      z_q   <= {fold_w, {ZGUARD{1'b0}}};
      cnt   <= '0;
      neg_q <= neg_w;
    end else if (st == ST_RUN) begin
      x_q <= x_n;
      y_q <= y_n;
      z_q <= z_n;
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        cos_q <= cos_w;
        sin_q <= sin_w;
        st    <= ST_HOLD;
      end
    end
  end

  // R2: acceptance clears ready and done on the following edge
  assert_accept_clears_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!ready && !done));

  // R2: a result only appears after the last iteration index
  assert_done_latency_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(cnt) == LAST));

  // R3: a request during a run only advances the iteration count
  assert_busy_ignores_start_R3: assert property (@(posedge clk) disable iff (rst)
    (!ready && start && cnt != LAST) |=> (!ready && cnt == $past(cnt) + 1'b1));

  // R5: held result stays frozen while no new angle is taken
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(cos_out) && $stable(sin_out)));

  // R7: the folded start angle is within a quarter turn
  assert_fold_range_R7: assert property (@(posedge clk) disable iff (rst)
    accept |=> (z_q <= QTR_Z && z_q >= -QTR_Z));

endmodule

// File: tb/tb_cordic_sincos.sv
module tb_cordic_sincos;
  localparam int ITER = 14;
  localparam int TOL  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] angle = '0;
  logic        ready, done;
  logic [15:0] cos_out, sin_out;

  always #10 clk = ~clk;

  cordic_sincos dut (
    .clk(clk), .rst(rst), .start(start), .angle(angle),
    .ready(ready), .done(done), .cos_out(cos_out), .sin_out(sin_out)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ideal(input int a, input bit want_sin);
    real ph, r;
    int v;
    ph = 2.0 * 3.14159265358979 * a / 32768.0;
    r  = (want_sin ? $sin(ph) : $cos(ph)) * 32768.0;
    v  = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // behavioural cycle model
  int m_left;
  bit m_done, m_ready;
  int exp_c, exp_s;
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_left <= 0; m_done <= 1'b0; m_ready <= 1'b1;
    end else if (start && m_ready) begin
      m_left  <= ITER;
      m_done  <= 1'b0;
      m_ready <= 1'b0;
      exp_c   <= ideal(int'($signed(angle)), 1'b0);
      exp_s   <= ideal(int'($signed(angle)), 1'b1);
    end else if (m_left > 0) begin
      m_left <= m_left - 1;
      if (m_left == 1) begin
        m_done <= 1'b1; m_ready <= 1'b1;
      end
    end
  end

  // per-cycle comparison against the model
  bit   prev_done = 1'b0;
  logic [15:0] prev_c, prev_s;
  always @(negedge clk) begin
    if (!rst) begin
      chk(ready == m_ready, "R2 ready", int'(ready), int'(m_ready));
      chk(done == m_done, "R2 done", int'(done), int'(m_done));
      if (done && m_done) begin
        chk(iabs(int'($signed(cos_out)) - exp_c) <= TOL, "R4 cos",
            int'($signed(cos_out)), exp_c);
        chk(iabs(int'($signed(sin_out)) - exp_s) <= TOL, "R4 sin",
            int'($signed(sin_out)), exp_s);
        if (prev_done) begin
          chk(cos_out == prev_c, "R5 cos hold", int'($signed(cos_out)), int'($signed(prev_c)));
          chk(sin_out == prev_s, "R5 sin hold", int'($signed(sin_out)), int'($signed(prev_s)));
        end
      end
      prev_done = done && !start;
      prev_c = cos_out;
      prev_s = sin_out;
    end else begin
      prev_done = 1'b0;
    end
  end

  int got_c, got_s;
  task automatic run(input int a);
    @(negedge clk);
    while (!ready) @(negedge clk);
    angle = 16'(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (ITER + 2) @(negedge clk);
    got_c = int'($signed(cos_out));
    got_s = int'($signed(sin_out));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int c0, s0;
    int lcg;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(cos_out == 16'd0, "R1 cos", int'(cos_out), 0);
    chk(sin_out == 16'd0, "R1 sin", int'(sin_out), 0);
    rst = 1'b0;
    @(negedge clk);

    // R4 cardinal angles; R6 saturation at zero
    run(0);
    chk(got_c >= 32759 && got_c <= 32767, "R6 cos(0)", got_c, 32767);
    c0 = got_c; s0 = got_s;
    run(-32768);
    chk(got_c == c0, "R7 -360 vs 0 cos", got_c, c0);
    chk(got_s == s0, "R7 -360 vs 0 sin", got_s, s0);
    run(8192);
    c0 = got_c; s0 = got_s;
    chk(got_s >= 32759, "R4 sin(90)", got_s, 32767);
    run(-24576);
    chk(got_c == c0, "R7 -270 vs 90 cos", got_c, c0);
    chk(got_s == s0, "R7 -270 vs 90 sin", got_s, s0);
    run(-8192);
    run(16384);
    chk(got_c <= -32760, "R4 cos(180)", got_c, -32768);
    run(-16384);
    run(4096);
    run(32767);

    // R3: request injected mid-run is ignored
    @(negedge clk);
    while (!ready) @(negedge clk);
    angle = 16'(1000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    angle = 16'(20000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (ITER) @(negedge clk);
    chk(iabs(int'($signed(cos_out)) - ideal(1000, 1'b0)) <= TOL, "R3 cos kept",
        int'($signed(cos_out)), ideal(1000, 1'b0));
    chk(iabs(int'($signed(sin_out)) - ideal(1000, 1'b1)) <= TOL, "R3 sin kept",
        int'($signed(sin_out)), ideal(1000, 1'b1));
    repeat (10) @(negedge clk);   // R5 hold observed by the per-cycle compare

    // R1: asynchronous reset in the middle of a run
    angle = 16'(3000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    #5 rst = 1'b1;
    #1;
    chk(ready == 1'b1, "R1 async ready", int'(ready), 1);
    chk(done == 1'b0, "R1 async done", int'(done), 0);
    chk(cos_out == 16'd0, "R1 async cos", int'(cos_out), 0);
    @(negedge clk);
    rst = 1'b0;

    // R4 pseudo-random sweep
    lcg = 12345;
    for (int k = 0; k < 40; k++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      run(((lcg >>> 8) & 16'hffff) - 32768);
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule